// File: doc/BRIEF.md
# Ethernet Transmit Status Register

This block keeps the status flags that a 10/100 Ethernet MAC transmitter reports for each frame. It presents them as one 16-bit read-only word. It also owns the bit that enables the transmitter. The transmit engine drives single-cycle event strobes: frame start and end, the collision results, carrier checks, underrun and the address type. A byte-time tick lets the block time deferral and collision windows by itself.

Each flag has its own clear rule. The per-frame result flags clear when a new frame starts. The deferral flags clear when a frame ends. The fatal-error flags clear when the host sets transmit enable again. The counter-rollover flag clears when the host reads the statistics counters. Any fatal error (underrun, late collision or lost carrier) also clears transmit enable in the same step.

At every frame end the block gives out a single snapshot of the word, so that it can be written as the first word of the frame's buffer. Later frames then overwrite the live register without losing that frame's result. The active-low link pin is synchronised and shown inverted in the word. Each change of the link state raises a one-cycle interrupt.

Top module: `eth_txstat_reg`

## Requirements
- R1: After reset, status_word, tx_enable, snap_valid and link_irq are all 0. Bits 13 and 8 of status_word always read 0.
- R2: A host_txen_set pulse makes tx_enable 1 on the next cycle, unless a fatal error arrives in the same cycle. It also clears the underrun (bit 15), late-collision (bit 9) and lost-carrier (bit 10) flags. A set event in the same cycle wins over this clear.
- R3: A host_txen_clr pulse with no frame in progress clears tx_enable on the next cycle. If a frame is in progress, tx_enable stays 1 until that frame's ev_frame_end, and clears on the cycle after it.
- R4: ev_underrun with early_tx_en high sets bit 15 and clears tx_enable. With early_tx_en low, ev_underrun has no effect.
- R5: ev_collision inside a frame, after more than LATE_COL_BYTES byte ticks since ev_frame_start, sets bit 9 and clears tx_enable. A collision at or before that count does neither.
- R6: ev_preamble_end with ev_crs low and crs_mon_en high sets bit 10 and clears tx_enable. With crs_mon_en low, or with carrier present, it has no effect.
- R7: More than EXC_DEF_BYTES byte ticks counted while tx_pending is high outside a frame set bit 11. Bit 11 clears at ev_frame_end.
- R8: ev_ifg_crs sets the deferred flag (bit 7). It clears at ev_frame_end.
- R9: The frame-result strobes set their own bits: success 0, single collision 1, multiple collisions 2, multicast 3, 16 collisions 4, SQE 5, broadcast 6. All seven bits clear at ev_frame_start.
- R10: ctr_max sets bit 12 and ctr_read clears it. When both arrive in the same cycle, the set wins.
- R11: Bit 14 equals the inverse of link_n_pin, two clock edges after the pin changes. link_irq pulses for one cycle in the same cycle that bit 14 changes.
- R12: One cycle after ev_frame_end, snap_valid is high for one cycle. snap_word then holds the word including that cycle's set events, and before that frame end's clears.
- R13: The byte-time counters saturate rather than wrap. A collision after 130 ticks (more than the 7-bit range that the default limit needs) still counts as late.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_txen_set | input | 1 | Host write that sets transmit enable |
| host_txen_clr | input | 1 | Host write that clears transmit enable |
| early_tx_en | input | 1 | Early transmit mode active (allows underrun) |
| crs_mon_en | input | 1 | Carrier monitoring enabled |
| ev_frame_start | input | 1 | Frame transmission begins |
| ev_frame_end | input | 1 | Frame transmission completes |
| ev_success | input | 1 | Frame sent successfully |
| ev_col_single | input | 1 | Frame had exactly one collision |
| ev_col_multi | input | 1 | Frame had several collisions |
| ev_col_16 | input | 1 | Frame aborted after 16 collisions |
| ev_collision | input | 1 | Collision seen now |
| ev_mcast | input | 1 | Frame was multicast |
| ev_bcast | input | 1 | Frame was broadcast |
| ev_sqe | input | 1 | Signal quality error reported |
| ev_underrun | input | 1 | Transmit data underrun |
| ev_preamble_end | input | 1 | End of preamble reached |
| ev_crs | input | 1 | Carrier sense level |
| ev_ifg_crs | input | 1 | Carrier seen early in the inter-frame gap |
| tx_pending | input | 1 | A frame waits to be sent |
| byte_tick | input | 1 | One byte time elapsed |
| link_n_pin | input | 1 | Link pin, active low, asynchronous |
| ctr_max | input | 1 | A 4-bit statistics counter reached 15 |
| ctr_read | input | 1 | Host read of the statistics counters |
| status_word | output | 16 | Live status word |
| snap_valid | output | 1 | Snapshot strobe for buffer write-back |
| snap_word | output | 16 | Frame status for buffer write-back |
| tx_enable | output | 1 | Transmit enable |
| link_irq | output | 1 | Link change interrupt pulse |

## Verification
The properties watch several rules on every cycle. A fatal error must drop transmit enable and set its own flag. An underrun outside early mode must leave the word alone. The rollover flag must follow its set strobe. Frame start and frame end must clear their flags. A link interrupt must coincide with a change of bit 14. A snapshot must follow a frame end. The unused bits must stay zero.

Other behaviour depends on history, so only the bench's scenarios can show it. These are the exact byte counts that make a collision late or a deferral excessive, and saturation past the counter's natural range. They also include a host clear that waits for the frame in progress to finish, and the snapshot contents: it must hold flags that the same frame end then clears from the live word.

// File: rtl/eth_txstat_pkg.sv
package eth_txstat_pkg;
   localparam int STAT_W = 16;

   localparam int B_SUCCESS  = 0;
   localparam int B_COL1     = 1;
   localparam int B_COLN     = 2;
   localparam int B_MCAST    = 3;
   localparam int B_COL16    = 4;
   localparam int B_SQE      = 5;
   localparam int B_BCAST    = 6;
   localparam int B_DEFER    = 7;
   localparam int B_LATECOL  = 9;
   localparam int B_LOSTCRS  = 10;
   localparam int B_EXCDEF   = 11;
   localparam int B_ROLL     = 12;
   localparam int B_LINK     = 14;
   localparam int B_UNDERRUN = 15;

   typedef logic [STAT_W-1:0] stat_word_t;

   // flags cleared when a frame starts
   localparam stat_word_t CLR_AT_START = 16'h007F;
   // flags cleared when a frame ends
   localparam stat_word_t CLR_AT_END   = 16'h0880;
   // flags cleared when the host re-enables transmit
   localparam stat_word_t CLR_AT_TXEN  = 16'h8600;
   // bits held in the flag register (link is live, 8 and 13 unused)
   localparam stat_word_t FLAG_MASK    = 16'h9EFF;
endpackage

// File: rtl/txstat_satcnt.sv
module txstat_satcnt #(
   parameter int LIMIT = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   output logic over
);
   localparam int CW = $clog2(LIMIT + 2);
   localparam logic [CW-1:0] TOP = CW'(LIMIT + 1);

   if (LIMIT < 1) begin : g_bad_limit
      $error("txstat_satcnt: LIMIT must be at least 1");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)              cnt_q <= '0;
      else if (clr)            cnt_q <= '0;
      else if (inc && cnt_q != TOP) cnt_q <= cnt_q + 1'b1;
   end

   assign over = (cnt_q == TOP);
endmodule

// File: rtl/txstat_linkmon.sv
module txstat_linkmon #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_n,
   output logic link_ok,
   output logic change
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("txstat_linkmon: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;

   for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) sync_q[0] <= 1'b1;
            else        sync_q[0] <= pin_n;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) sync_q[i] <= 1'b1;
            else        sync_q[i] <= sync_q[i-1];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= sync_q[SYNC_STAGES-1];
   end

   assign link_ok = ~sync_q[SYNC_STAGES-1];
   assign change  = sync_q[SYNC_STAGES-1] ^ prev_q;
endmodule

// File: rtl/eth_txstat_reg.sv
module eth_txstat_reg
   import eth_txstat_pkg::*;
#(
   parameter int LATE_COL_BYTES = 64,
   parameter int EXC_DEF_BYTES  = 3036,
   parameter int SYNC_STAGES    = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        host_txen_set,
   input  logic        host_txen_clr,
   input  logic        early_tx_en,
   input  logic        crs_mon_en,
   input  logic        ev_frame_start,
   input  logic        ev_frame_end,
   input  logic        ev_success,
   input  logic        ev_col_single,
   input  logic        ev_col_multi,
   input  logic        ev_col_16,
   input  logic        ev_collision,
   input  logic        ev_mcast,
   input  logic        ev_bcast,
   input  logic        ev_sqe,
   input  logic        ev_underrun,
   input  logic        ev_preamble_end,
   input  logic        ev_crs,
   input  logic        ev_ifg_crs,
   input  logic        tx_pending,
   input  logic        byte_tick,
   input  logic        link_n_pin,
   input  logic        ctr_max,
   input  logic        ctr_read,
   output logic [15:0] status_word,
   output logic        snap_valid,
   output logic [15:0] snap_word,
   output logic        tx_enable,
   output logic        link_irq
);
   if (STAT_W != 16) begin : g_bad_width
      $error("eth_txstat_reg: status word must be 16 bits");
   end
   if (EXC_DEF_BYTES <= LATE_COL_BYTES) begin : g_bad_windows
      $error("eth_txstat_reg: deferral limit must exceed late-collision window");
   end

   logic       in_frame_q, stop_pend_q, txen_q;
   stat_word_t flags_q, set_vec, clr_vec, live_word;
   logic       late_window, exc_over, link_ok;
   logic       ev_latecol, ev_lostcrs, ev_urun, fatal;

   // byte time since frame start (late-collision window)
   txstat_satcnt #(.LIMIT(LATE_COL_BYTES)) u_colwin (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (ev_frame_start),
      .inc   (byte_tick & in_frame_q),
      .over  (late_window)
   );

   // byte time spent waiting to transmit (deferral)
   txstat_satcnt #(.LIMIT(EXC_DEF_BYTES)) u_defwin (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (ev_frame_start | ev_frame_end),
      .inc   (byte_tick & tx_pending & ~in_frame_q),
      .over  (exc_over)
   );

   txstat_linkmon #(.SYNC_STAGES(SYNC_STAGES)) u_link (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin_n   (link_n_pin),
      .link_ok (link_ok),
      .change  (link_irq)
   );

   assign ev_urun    = ev_underrun & early_tx_en;
   assign ev_latecol = ev_collision & in_frame_q & late_window;
   assign ev_lostcrs = ev_preamble_end & crs_mon_en & ~ev_crs;
   assign fatal      = ev_urun | ev_latecol | ev_lostcrs;

   always_comb begin
      set_vec             = '0;
      set_vec[B_SUCCESS]  = ev_success;
      set_vec[B_COL1]     = ev_col_single;
      set_vec[B_COLN]     = ev_col_multi;
      set_vec[B_MCAST]    = ev_mcast;
      set_vec[B_COL16]    = ev_col_16;
      set_vec[B_SQE]      = ev_sqe;
      set_vec[B_BCAST]    = ev_bcast;
      set_vec[B_DEFER]    = ev_ifg_crs;
      set_vec[B_LATECOL]  = ev_latecol;
      set_vec[B_LOSTCRS]  = ev_lostcrs;
      set_vec[B_EXCDEF]   = exc_over & ~ev_frame_end;
      set_vec[B_ROLL]     = ctr_max;
      set_vec[B_UNDERRUN] = ev_urun;

      clr_vec = '0;
      if (ev_frame_start) clr_vec = clr_vec | CLR_AT_START;
      if (ev_frame_end)   clr_vec = clr_vec | CLR_AT_END;
      if (host_txen_set)  clr_vec = clr_vec | CLR_AT_TXEN;
      if (ctr_read)       clr_vec[B_ROLL] = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flags_q     <= '0;
         in_frame_q  <= 1'b0;
         stop_pend_q <= 1'b0;
         txen_q      <= 1'b0;
         snap_valid  <= 1'b0;
         snap_word   <= '0;
      end else begin
         flags_q    <= (set_vec | (flags_q & ~clr_vec)) & FLAG_MASK;
         in_frame_q <= ev_frame_start | (in_frame_q & ~ev_frame_end);
         stop_pend_q <= (host_txen_clr & in_frame_q)
                      | (stop_pend_q & ~ev_frame_end & ~host_txen_set & ~fatal);
         if (fatal)                              txen_q <= 1'b0;
         else if (host_txen_set)                 txen_q <= 1'b1;
         else if (host_txen_clr && !in_frame_q)  txen_q <= 1'b0;
         else if (stop_pend_q && ev_frame_end)   txen_q <= 1'b0;
         snap_valid <= ev_frame_end;
         if (ev_frame_end) snap_word <= live_word | (set_vec & FLAG_MASK);
      end
   end

   always_comb begin
      live_word         = flags_q;
      live_word[B_LINK] = link_ok;
   end

   assign status_word = live_word;
   assign tx_enable   = txen_q;
endmodule

// File: rtl/txstat_chk.sv
module txstat_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        early_tx_en,
   input logic        crs_mon_en,
   input logic        ev_frame_start,
   input logic        ev_frame_end,
   input logic        ev_bcast,
   input logic        ev_underrun,
   input logic        ev_preamble_end,
   input logic        ev_crs,
   input logic        ev_ifg_crs,
   input logic        ctr_max,
   input logic [15:0] status_word,
   input logic        snap_valid,
   input logic        tx_enable,
   input logic        link_irq
);
   // R1
   unused_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status_word[13] == 1'b0 && status_word[8] == 1'b0);

   // R4
   underrun_fatal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_underrun && early_tx_en |=> !tx_enable && status_word[15]);

   // R4
   underrun_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_underrun && !early_tx_en && !status_word[15] |=> !status_word[15]);

   // R6
   lost_carrier_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_preamble_end && crs_mon_en && !ev_crs |=> !tx_enable && status_word[10]);

   // R8
   defer_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_frame_end && !ev_ifg_crs |=> !status_word[7]);

   // R9
   bcast_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ev_frame_start && !ev_bcast |=> !status_word[6]);

   // R10
   rollover_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctr_max |=> status_word[12]);

   // R11
   link_irq_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      link_irq |-> status_word[14] != $past(status_word[14]));

   // R12
   snap_follows_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      snap_valid |-> $past(ev_frame_end));
endmodule

bind eth_txstat_reg txstat_chk u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .early_tx_en     (early_tx_en),
   .crs_mon_en      (crs_mon_en),
   .ev_frame_start  (ev_frame_start),
   .ev_frame_end    (ev_frame_end),
   .ev_bcast        (ev_bcast),
   .ev_underrun     (ev_underrun),
   .ev_preamble_end (ev_preamble_end),
   .ev_crs          (ev_crs),
   .ev_ifg_crs      (ev_ifg_crs),
   .ctr_max         (ctr_max),
   .status_word     (status_word),
   .snap_valid      (snap_valid),
   .tx_enable       (tx_enable),
   .link_irq        (link_irq)
);

// File: tb/eth_txstat_reg_tb.sv
module eth_txstat_reg_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic host_txen_set = 0, host_txen_clr = 0, early_tx_en = 0, crs_mon_en = 0;
   logic ev_frame_start = 0, ev_frame_end = 0, ev_success = 0, ev_col_single = 0;
   logic ev_col_multi = 0, ev_col_16 = 0, ev_collision = 0, ev_mcast = 0, ev_bcast = 0;
   logic ev_sqe = 0, ev_underrun = 0, ev_preamble_end = 0, ev_crs = 0, ev_ifg_crs = 0;
   logic tx_pending = 0, byte_tick = 0, link_n_pin = 1, ctr_max = 0, ctr_read = 0;
   logic [15:0] status_word, snap_word;
   logic snap_valid, tx_enable, link_irq;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;
   logic [15:0] exp_q[$];

   always #4 clk = ~clk;

   eth_txstat_reg u_dut (
      .clk(clk), .rst_n(rst_n), .host_txen_set(host_txen_set), .host_txen_clr(host_txen_clr),
      .early_tx_en(early_tx_en), .crs_mon_en(crs_mon_en), .ev_frame_start(ev_frame_start),
      .ev_frame_end(ev_frame_end), .ev_success(ev_success), .ev_col_single(ev_col_single),
      .ev_col_multi(ev_col_multi), .ev_col_16(ev_col_16), .ev_collision(ev_collision),
      .ev_mcast(ev_mcast), .ev_bcast(ev_bcast), .ev_sqe(ev_sqe), .ev_underrun(ev_underrun),
      .ev_preamble_end(ev_preamble_end), .ev_crs(ev_crs), .ev_ifg_crs(ev_ifg_crs),
      .tx_pending(tx_pending), .byte_tick(byte_tick), .link_n_pin(link_n_pin),
      .ctr_max(ctr_max), .ctr_read(ctr_read), .status_word(status_word),
      .snap_valid(snap_valid), .snap_word(snap_word), .tx_enable(tx_enable),
      .link_irq(link_irq)
   );

   task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // advance one cycle and drop all strobes
   task automatic tick();
      @(negedge clk);
      host_txen_set = 0; host_txen_clr = 0; ev_frame_start = 0; ev_frame_end = 0;
      ev_success = 0; ev_col_single = 0; ev_col_multi = 0; ev_col_16 = 0;
      ev_collision = 0; ev_mcast = 0; ev_bcast = 0; ev_sqe = 0; ev_underrun = 0;
      ev_preamble_end = 0; ev_ifg_crs = 0; byte_tick = 0; ctr_max = 0; ctr_read = 0;
   endtask

   task automatic bytes(int n);
      for (int i = 0; i < n; i++) begin
         byte_tick = 1; tick();
      end
   endtask

   // scoreboard monitor for frame snapshots (R12)
   always @(negedge clk) begin
      if (rst_n && snap_valid) begin
         if (exp_q.size() == 0) begin
            n_chk++; n_fail++;
            $display("FAIL R12 actual=%h expected=none", snap_word);
         end else begin
            chk("R12 snapshot", snap_word, exp_q.pop_front());
         end
      end
   end

   initial begin
      #(8 * 200000);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=running expected=done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      chk("R1 status", status_word, 16'h0000);
      chk("R1 txen/snap/irq", {13'd0, tx_enable, snap_valid, link_irq}, 16'h0000);

      host_txen_set = 1; tick();
      chk("R2 enable", {15'd0, tx_enable}, 16'h0001);

      // R9 frame result flags
      ev_frame_start = 1; tick();
      ev_success = 1; ev_bcast = 1; ev_col_single = 1; ev_frame_end = 1;
      exp_q.push_back(16'h0043); tick();
      chk("R9 result bits", status_word, 16'h0043);
      ev_frame_start = 1; tick();
      chk("R9 cleared at start", status_word, 16'h0000);
      ev_mcast = 1; tick();
      ev_success = 1; ev_col_multi = 1; ev_frame_end = 1;
      exp_q.push_back(16'h000D); tick();
      chk("R9 multi/mcast", status_word, 16'h000D);

      // R8 deferred
      ev_ifg_crs = 1; tick();
      chk("R8 set", status_word, 16'h008D);
      ev_frame_start = 1; tick();
      chk("R8 kept at start", status_word, 16'h0080);
      ev_success = 1; ev_frame_end = 1;
      exp_q.push_back(16'h0081); tick();
      chk("R8 cleared at end", status_word, 16'h0001);

      // R4 underrun
      ev_underrun = 1; tick();
      chk("R4 ignored w/o early", {status_word[15], 14'd0, tx_enable}, 16'h0001);
      early_tx_en = 1; ev_underrun = 1; tick();
      chk("R4 underrun", {status_word[15], 14'd0, tx_enable}, 16'h8000);
      early_tx_en = 0;
      host_txen_set = 1; tick();
      chk("R2 clears underrun", {status_word[15], 14'd0, tx_enable}, 16'h0001);

      // R5 late collision boundary
      ev_frame_start = 1; tick();
      bytes(64);
      ev_collision = 1; tick();
      chk("R5 not late at limit", {status_word[9], 14'd0, tx_enable}, 16'h0001);
      bytes(1);
      ev_collision = 1; tick();
      chk("R5 late", {status_word[9], 14'd0, tx_enable}, 16'h8000);
      ev_frame_end = 1; exp_q.push_back(16'h0200); tick();
      host_txen_set = 1; tick();
      chk("R2 clears latecol", {status_word[9], 14'd0, tx_enable}, 16'h0001);

      // R13 saturation
      ev_frame_start = 1; tick();
      bytes(130);
      ev_collision = 1; tick();
      chk("R13 saturate", {status_word[9], 14'd0, tx_enable}, 16'h8000);
      ev_frame_end = 1; exp_q.push_back(16'h0200); tick();
      host_txen_set = 1; tick();

      // R6 lost carrier
      ev_preamble_end = 1; tick();
      chk("R6 monitor off", {status_word[10], 14'd0, tx_enable}, 16'h0001);
      crs_mon_en = 1; ev_crs = 1; ev_preamble_end = 1; tick();
      chk("R6 carrier present", {status_word[10], 14'd0, tx_enable}, 16'h0001);
      ev_crs = 0; ev_preamble_end = 1; tick();
      chk("R6 lost", {status_word[10], 14'd0, tx_enable}, 16'h8000);
      crs_mon_en = 0;
      host_txen_set = 1; tick();
      chk("R2 clears lostcrs", status_word, 16'h0000);

      // R3 host clear
      ev_frame_start = 1; tick();
      host_txen_clr = 1; tick();
      chk("R3 held in frame", {15'd0, tx_enable}, 16'h0001);
      ev_frame_end = 1; exp_q.push_back(16'h0000); tick();
      chk("R3 stop at end", {15'd0, tx_enable}, 16'h0000);
      host_txen_set = 1; tick();
      host_txen_clr = 1; tick();
      chk("R3 idle clear", {15'd0, tx_enable}, 16'h0000);
      host_txen_set = 1; tick();

      // R10 rollover
      ctr_max = 1; tick();
      chk("R10 set", status_word, 16'h1000);
      ctr_max = 1; ctr_read = 1; tick();
      chk("R10 set wins", status_word, 16'h1000);
      ctr_read = 1; tick();
      chk("R10 cleared", status_word, 16'h0000);

      // R7 excessive deferral
      tx_pending = 1;
      bytes(3036);
      tick();
      chk("R7 at limit", status_word, 16'h0000);
      bytes(1);
      tick();
      chk("R7 exceeded", status_word, 16'h0800);
      tx_pending = 0;
      ev_frame_start = 1; tick();
      ev_success = 1; ev_frame_end = 1; exp_q.push_back(16'h0801); tick();
      chk("R7 cleared at end", status_word, 16'h0001);

      // R11 link
      link_n_pin = 0; tick();
      chk("R11 first edge", {status_word[14], 14'd0, link_irq}, 16'h0000);
      tick();
      chk("R11 link up", {status_word[14], 14'd0, link_irq}, 16'h8001);
      tick();
      chk("R11 irq one cycle", {status_word[14], 14'd0, link_irq}, 16'h8000);
      link_n_pin = 1; tick(); tick();
      chk("R11 link down", {status_word[14], 14'd0, link_irq}, 16'h0001);

      repeat (3) tick();
      chk("R12 queue drained", 16'(exp_q.size()), 16'h0000);
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule